// File: doc/BRIEF.md
# Hardware Page-Table Walker

This block resolves translation misses without software help. The TLB hands it a missing virtual page number together with the address-space tag. The walker then reads one 64-bit page-table entry per level through a single read port, starting from a root table address. It indexes each level with its own 9-bit slice of the page number. A valid leaf produces a refill record, which waits in a one-entry fill buffer until the TLB takes it. An entry whose valid bit is clear ends the walk with a one-cycle page-fault pulse and no refill.

While no walk is active, the block also serves accessed/dirty update requests from the TLB. Each one is a read-modify-write of the in-memory entry at an address the TLB supplies. That address is the leaf address that was returned with the refill. The update reads the entry, ORs in the requested flag bits and writes the result back. Only one memory read is outstanding at a time, and memory latency may vary.

Top module: `ptw_walker`

## Requirements
- R1: After reset, miss_ready and upd_ready are 1 and fill_valid, fault_valid, rd_req_valid and wr_valid are 0.
- R2: The first read of a walk goes to root_base + vpn[17:9]*8. The second read goes to (next-level PFN << 12) + vpn[8:0]*8.
- R3: Entry layout: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 5 global, bit 6 accessed, bit 7 dirty, bits 53:10 PFN. An entry is a leaf when any of read, write or execute is set. A valid leaf at the second level yields a refill with that PFN, perm = {execute, write, read}, the global bit, the request VPN and ASID, and the leaf's address.
- R4: A valid bit of 0 at either level gives a one-cycle fault_valid with the request VPN and ASID, and no refill.
- R5: A valid leaf at the root level maps a large region. The refill PFN is the entry PFN with its low 9 bits replaced by vpn[8:0].
- R6: A valid non-leaf entry at the second level ends the walk with a fault and no refill.
- R7: A refill stays on the fill outputs, unchanged, until fill_ready. No new miss is accepted while a walk or a held refill is in progress.
- R8: At most one memory read is outstanding. rd_req_valid is not raised again until the response returns.
- R9: An update reads upd_addr, then writes the same address with the read data ORed with bit 6 (if upd_set_acc) and bit 7 (if upd_set_dirty).
- R10: When an update and a miss are both presented in idle, the update is served first, and miss_ready is 0 while upd_valid is high.
- R11: A read request holds its address stable while rd_req_ready is low.
- R12: The results do not depend on the number of request stall cycles or on the response latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | 56 | Physical address of the root table (page aligned) |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker can take a miss |
| miss_vpn | input | 18 | Missing virtual page number |
| miss_asid | input | 16 | Address-space tag of the miss |
| fill_valid | output | 1 | Refill record held for the TLB |
| fill_ready | input | 1 | TLB accepts the refill |
| fill_vpn | output | 18 | Refill page number |
| fill_asid | output | 16 | Refill address-space tag |
| fill_pfn | output | 44 | Translated frame number |
| fill_perm | output | 3 | {execute, write, read} |
| fill_global | output | 1 | Entry shared by all address spaces |
| fill_pte_addr | output | 56 | Address of the leaf entry |
| fault_valid | output | 1 | One-cycle page-fault pulse |
| fault_vpn | output | 18 | Faulting page number |
| fault_asid | output | 16 | Faulting address-space tag |
| upd_valid | input | 1 | Accessed/dirty update request |
| upd_ready | output | 1 | Update accepted |
| upd_addr | input | 56 | Entry address to update |
| upd_set_acc | input | 1 | Set the accessed bit |
| upd_set_dirty | input | 1 | Set the dirty bit |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_ready | input | 1 | Memory takes the read |
| rd_req_addr | output | 56 | Read address |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 64 | Read data |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Memory takes the write |
| wr_addr | output | 56 | Write address |
| wr_data | output | 64 | Write data |

## Verification
The assertions assume that the memory returns exactly one response per accepted read and never sends a response when no read is pending. They also assume that the TLB keeps each request's fields steady while it is valid. The bench memory model follows both rules. It issues a single rd_rsp_valid pulse for each handshake, after a programmable latency, and it applies request stalls only before a handshake. The bench changes miss and update inputs only on falling edges, once the block has accepted the previous request.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PTE_W       = 64;
  localparam int ENTRY_LOG2  = 3;
  localparam int BIT_VALID   = 0;
  localparam int BIT_RD      = 1;
  localparam int BIT_WR      = 2;
  localparam int BIT_EX      = 3;
  localparam int BIT_GLOB    = 5;
  localparam int BIT_ACC     = 6;
  localparam int BIT_DIRTY   = 7;
  localparam int BIT_PFN_LO  = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WALK_REQ,
    ST_WALK_RSP,
    ST_HOLD_FILL,
    ST_UPD_REQ,
    ST_UPD_RSP,
    ST_UPD_WR
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int LEVELS = 2,
  parameter int PA_W   = 56,
  localparam int VPN_W = IDX_W * LEVELS,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [PA_W-1:0]  base,
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  addr
);
  logic [IDX_W-1:0] idx_tbl [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign idx_tbl[g] = vpn[g*IDX_W +: IDX_W];
  end

  logic [PA_W-1:0] offs;
  always_comb begin
    offs = '0;
    offs[ENTRY_LOG2 +: IDX_W] = idx_tbl[level];
    addr = base + offs;
  end
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
#(
  parameter int IDX_W  = 9,
  parameter int LEVELS = 2,
  parameter int PFN_W  = 44,
  localparam int VPN_W = IDX_W * LEVELS,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [LVL_W-1:0] level,
  input  logic [VPN_W-1:0] vpn,
  output logic             ent_valid,
  output logic             ent_leaf,
  output logic [2:0]       ent_perm,
  output logic             ent_glob,
  output logic [PFN_W-1:0] pfn_raw,
  output logic [PFN_W-1:0] pfn_eff
);
  logic [PFN_W-1:0] pfn_by_lvl [LEVELS];

  assign ent_valid = pte[BIT_VALID];
  assign ent_perm  = {pte[BIT_EX], pte[BIT_WR], pte[BIT_RD]};
  assign ent_leaf  = |ent_perm;
  assign ent_glob  = pte[BIT_GLOB];
  assign pfn_raw   = pte[BIT_PFN_LO +: PFN_W];

  // A leaf found above the last level covers a larger region: the low
  // page-number slices pass straight through into the frame number.
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    if (g == 0) begin : g_base
      assign pfn_by_lvl[g] = pfn_raw;
    end else begin : g_large
      assign pfn_by_lvl[g] = {pfn_raw[PFN_W-1:g*IDX_W], vpn[g*IDX_W-1:0]};
    end
  end

  assign pfn_eff = pfn_by_lvl[level];
endmodule

// File: rtl/ptw_fill_buf.sv
module ptw_fill_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] dout
);
  logic full_d;
  logic full_en;

  always_comb begin
    full_en = load | take;
    full_d  = load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       full <= 1'b0;
    else if (full_en) full <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load) dout <= din;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int IDX_W    = 9,
  parameter int LEVELS   = 2,
  parameter int ASID_W   = 16,
  parameter int PFN_W    = 44,
  parameter int PG_SHIFT = 12,
  localparam int VPN_W   = IDX_W * LEVELS,
  localparam int PA_W    = PFN_W + PG_SHIFT,
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int FILL_W  = VPN_W + ASID_W + PFN_W + 3 + 1 + PA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   root_base,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [VPN_W-1:0]  miss_vpn,
  input  logic [ASID_W-1:0] miss_asid,
  output logic              fill_valid,
  input  logic              fill_ready,
  output logic [VPN_W-1:0]  fill_vpn,
  output logic [ASID_W-1:0] fill_asid,
  output logic [PFN_W-1:0]  fill_pfn,
  output logic [2:0]        fill_perm,
  output logic              fill_global,
  output logic [PA_W-1:0]   fill_pte_addr,
  output logic              fault_valid,
  output logic [VPN_W-1:0]  fault_vpn,
  output logic [ASID_W-1:0] fault_asid,
  input  logic              upd_valid,
  output logic              upd_ready,
  input  logic [PA_W-1:0]   upd_addr,
  input  logic              upd_set_acc,
  input  logic              upd_set_dirty,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [PA_W-1:0]   rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [PTE_W-1:0]  rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [PA_W-1:0]   wr_addr,
  output logic [PTE_W-1:0]  wr_data
);
  walk_state_e state_q, state_d;

  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic [PA_W-1:0]   base_q, base_d;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [PA_W-1:0]   uaddr_q;
  logic [1:0]        uflags_q;
  logic [PTE_W-1:0]  wdata_q, wdata_d;
  logic              fault_q;

  logic take_miss, take_upd, descend, fault_set, buf_load, wdata_en;
  logic base_en;

  logic [PA_W-1:0]  walk_addr;
  logic             dec_valid, dec_leaf, dec_glob;
  logic [2:0]       dec_perm;
  logic [PFN_W-1:0] dec_pfn_raw, dec_pfn_eff;
  logic [PTE_W-1:0] ad_mask;

  ptw_addr_gen #(.IDX_W(IDX_W), .LEVELS(LEVELS), .PA_W(PA_W)) u_addr (
    .base  (base_q),
    .vpn   (vpn_q),
    .level (lvl_q),
    .addr  (walk_addr)
  );

  ptw_pte_decode #(.IDX_W(IDX_W), .LEVELS(LEVELS), .PFN_W(PFN_W)) u_dec (
    .pte       (rd_rsp_data),
    .level     (lvl_q),
    .vpn       (vpn_q),
    .ent_valid (dec_valid),
    .ent_leaf  (dec_leaf),
    .ent_perm  (dec_perm),
    .ent_glob  (dec_glob),
    .pfn_raw   (dec_pfn_raw),
    .pfn_eff   (dec_pfn_eff)
  );

  logic [FILL_W-1:0] fill_din, fill_dout;
  assign fill_din = {vpn_q, asid_q, dec_pfn_eff, dec_perm, dec_glob, walk_addr};

  ptw_fill_buf #(.W(FILL_W)) u_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (buf_load),
    .din   (fill_din),
    .take  (fill_ready),
    .full  (fill_valid),
    .dout  (fill_dout)
  );

  assign {fill_vpn, fill_asid, fill_pfn, fill_perm, fill_global, fill_pte_addr} = fill_dout;

  always_comb begin
    ad_mask            = '0;
    ad_mask[BIT_ACC]   = uflags_q[0];
    ad_mask[BIT_DIRTY] = uflags_q[1];
  end

  // Next-state and control decisions
  always_comb begin
    state_d   = state_q;
    take_miss = 1'b0;
    take_upd  = 1'b0;
    descend   = 1'b0;
    fault_set = 1'b0;
    buf_load  = 1'b0;
    wdata_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (upd_valid) begin
          take_upd = 1'b1;
          state_d  = ST_UPD_REQ;
        end else if (miss_valid) begin
          take_miss = 1'b1;
          state_d   = ST_WALK_REQ;
        end
      end
      ST_WALK_REQ: if (rd_req_ready) state_d = ST_WALK_RSP;
      ST_WALK_RSP: begin
        if (rd_rsp_valid) begin
          if (!dec_valid) begin
            fault_set = 1'b1;
            state_d   = ST_IDLE;
          end else if (dec_leaf) begin
            buf_load = 1'b1;
            state_d  = ST_HOLD_FILL;
          end else if (lvl_q == '0) begin
            fault_set = 1'b1;
            state_d   = ST_IDLE;
          end else begin
            descend = 1'b1;
            state_d = ST_WALK_REQ;
          end
        end
      end
      ST_HOLD_FILL: if (fill_ready) state_d = ST_IDLE;
      ST_UPD_REQ:   if (rd_req_ready) state_d = ST_UPD_RSP;
      ST_UPD_RSP: begin
        if (rd_rsp_valid) begin
          wdata_en = 1'b1;
          state_d  = ST_UPD_WR;
        end
      end
      ST_UPD_WR:    if (wr_ready) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    base_en = take_miss | descend;
    base_d  = take_miss ? root_base : {dec_pfn_raw, {PG_SHIFT{1'b0}}};
    lvl_d   = take_miss ? LVL_W'(LEVELS - 1) : lvl_q - 1'b1;
    wdata_d = rd_rsp_data | ad_mask;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_set;
    end
  end

  always_ff @(posedge clk) begin
    if (take_miss) begin
      vpn_q  <= miss_vpn;
      asid_q <= miss_asid;
    end
    if (base_en) begin
      base_q <= base_d;
      lvl_q  <= lvl_d;
    end
    if (take_upd) begin
      uaddr_q  <= upd_addr;
      uflags_q <= {upd_set_dirty, upd_set_acc};
    end
    if (wdata_en) wdata_q <= wdata_d;
  end

  // Outputs
  assign miss_ready   = (state_q == ST_IDLE) && !upd_valid;
  assign upd_ready    = (state_q == ST_IDLE);
  assign rd_req_valid = (state_q == ST_WALK_REQ) || (state_q == ST_UPD_REQ);
  assign rd_req_addr  = (state_q == ST_UPD_REQ) ? uaddr_q : walk_addr;
  assign wr_valid     = (state_q == ST_UPD_WR);
  assign wr_addr      = uaddr_q;
  assign wr_data      = wdata_q;
  assign fault_valid  = fault_q;
  assign fault_vpn    = vpn_q;
  assign fault_asid   = asid_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int VPN_W = 18,
  parameter int PA_W  = 56,
  parameter int PFN_W = 44
) (
  input logic             clk,
  input logic             rst_n,
  input logic             miss_ready,
  input logic             upd_valid,
  input logic             upd_ready,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PFN_W-1:0] fill_pfn,
  input logic             fault_valid,
  input logic             rd_req_valid,
  input logic             rd_req_ready,
  input logic [PA_W-1:0]  rd_req_addr,
  input logic             rd_rsp_valid
);
  logic [1:0] pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else if ((rd_req_valid && rd_req_ready) && !rd_rsp_valid) pending <= pending + 2'd1;
    else if (!(rd_req_valid && rd_req_ready) && rd_rsp_valid && pending != '0) pending <= pending - 2'd1;
  end

  // R8: no second read while one is in flight
  p_one_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> pending == 2'd0);

  // R11: stalled read holds its address
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  // R7: refill held unchanged until taken
  p_fill_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=> (fill_valid && $stable(fill_pfn) && $stable(fill_vpn)));

  // R7: no miss accepted while a refill waits
  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !miss_ready);

  // R4: fault is a single-cycle pulse
  p_fault_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);

  // R4: a fault never comes with a refill
  p_fault_nofill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !fill_valid);

  // R10: update wins over a miss in idle
  p_upd_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_ready) |-> !miss_ready);
endmodule

bind ptw_walker ptw_walker_chk #(.VPN_W(VPN_W), .PA_W(PA_W), .PFN_W(PFN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .miss_ready   (miss_ready),
  .upd_valid    (upd_valid),
  .upd_ready    (upd_ready),
  .fill_valid   (fill_valid),
  .fill_ready   (fill_ready),
  .fill_vpn     (fill_vpn),
  .fill_pfn     (fill_pfn),
  .fault_valid  (fault_valid),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_rsp_valid (rd_rsp_valid)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [55:0] root_base;
  logic        miss_valid, miss_ready;
  logic [17:0] miss_vpn;
  logic [15:0] miss_asid;
  logic        fill_valid, fill_ready;
  logic [17:0] fill_vpn;
  logic [15:0] fill_asid;
  logic [43:0] fill_pfn;
  logic [2:0]  fill_perm;
  logic        fill_global;
  logic [55:0] fill_pte_addr;
  logic        fault_valid;
  logic [17:0] fault_vpn;
  logic [15:0] fault_asid;
  logic        upd_valid, upd_ready;
  logic [55:0] upd_addr;
  logic        upd_set_acc, upd_set_dirty;
  logic        rd_req_valid, rd_req_ready;
  logic [55:0] rd_req_addr;
  logic        rd_rsp_valid;
  logic [63:0] rd_rsp_data;
  logic        wr_valid, wr_ready;
  logic [55:0] wr_addr;
  logic [63:0] wr_data;

  always #10 clk = ~clk;

  ptw_walker dut (.*);

  int errs = 0;
  int checks = 0;

  // ---------------- memory model ----------------
  logic [63:0] mem [logic [55:0]];
  logic [55:0] rd_log[$];
  logic [55:0] wa_log[$];
  logic [63:0] wd_log[$];
  int lat_cfg = 1;
  int stall_cfg = 0;
  int stall_left = 0;
  bit pend = 0;
  int cnt = 0;
  logic [63:0] pend_data;

  function automatic logic [63:0] mem_rd(input logic [55:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  initial begin
    rd_req_ready = 1'b0;
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = '0;
    wr_ready     = 1'b1;
    forever begin
      @(negedge clk);
      rd_rsp_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = pend_data;
          pend = 0;
        end else cnt--;
      end
      rd_req_ready = 1'b0;
      if (rst_n && rd_req_valid && !pend && !rd_rsp_valid) begin
        if (stall_left > 0) stall_left--;
        else begin
          rd_req_ready = 1'b1;
          rd_log.push_back(rd_req_addr);
          pend_data  = mem_rd(rd_req_addr);
          pend       = 1;
          cnt        = lat_cfg;
          stall_left = stall_cfg;
        end
      end
      if (rst_n && wr_valid && wr_ready) begin
        mem[wr_addr] = wr_data;
        wa_log.push_back(wr_addr);
        wd_log.push_back(wr_data);
      end
    end
  end

  // ---------------- helpers ----------------
  // Entry layout per R3: valid b0, read b1, write b2, exec b3, global b5, PFN b53:10
  function automatic logic [63:0] mk_ptr(input logic [43:0] pfn);
    return ({20'h0, pfn} << 10) | 64'h1;
  endfunction

  function automatic logic [63:0] mk_leaf(input logic [43:0] pfn, input logic [2:0] perm, input bit g);
    return ({20'h0, pfn} << 10) | (64'(g) << 5) | (64'(perm) << 1) | 64'h1;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [17:0] c_vpn;
  logic [15:0] c_asid;
  logic [43:0] c_pfn;
  logic [2:0]  c_perm;
  logic        c_glob;
  logic [55:0] c_paddr;

  task automatic do_miss(input logic [17:0] vpn, input logic [15:0] asid,
                         output bit got_fill, output bit got_fault);
    @(negedge clk);
    miss_vpn = vpn; miss_asid = asid; miss_valid = 1'b1;
    while (!miss_ready) @(negedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    got_fill = 0; got_fault = 0;
    for (int i = 0; i < 400 && !got_fill && !got_fault; i++) begin
      if (fill_valid && fill_ready) begin
        got_fill = 1;
        c_vpn = fill_vpn; c_asid = fill_asid; c_pfn = fill_pfn;
        c_perm = fill_perm; c_glob = fill_global; c_paddr = fill_pte_addr;
      end else if (fault_valid) begin
        got_fault = 1;
        c_vpn = fault_vpn; c_asid = fault_asid;
      end else @(negedge clk);
    end
  endtask

  localparam logic [55:0] ROOT   = 56'h1000_0000;
  localparam logic [55:0] L0BASE = 56'h2000_0000;

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1", "miss_ready", miss_ready, 1);
    chk("R1", "upd_ready", upd_ready, 1);
    chk("R1", "fill_valid", fill_valid, 0);
    chk("R1", "fault_valid", fault_valid, 0);
    chk("R1", "rd_req_valid", rd_req_valid, 0);
    chk("R1", "wr_valid", wr_valid, 0);
  endtask

  task automatic t_walk_two_level();
    bit f, e;
    rd_log.delete();
    do_miss({9'h045, 9'h123}, 16'h00A1, f, e);
    chk("R3", "fill seen", f, 1);
    chk("R2", "read count", rd_log.size(), 2);
    if (rd_log.size() == 2) begin
      chk("R2", "root read addr", rd_log[0], ROOT + 56'h228);
      chk("R2", "leaf read addr", rd_log[1], L0BASE + 56'h918);
    end
    chk("R3", "pfn", c_pfn, 44'hABCDE);
    chk("R3", "perm", c_perm, 3'b011);
    chk("R3", "global", c_glob, 1);
    chk("R3", "vpn", c_vpn, {9'h045, 9'h123});
    chk("R3", "asid", c_asid, 16'h00A1);
    chk("R3", "pte addr", c_paddr, L0BASE + 56'h918);
  endtask

  task automatic t_fault_root();
    bit f, e;
    rd_log.delete();
    do_miss({9'h046, 9'h001}, 16'h0007, f, e);
    chk("R4", "fault at root", e, 1);
    chk("R4", "fault vpn", c_vpn, {9'h046, 9'h001});
    chk("R4", "fault asid", c_asid, 16'h0007);
    chk("R4", "reads before root fault", rd_log.size(), 1);
    repeat (3) @(negedge clk);
    chk("R4", "no refill after root fault", fill_valid, 0);
  endtask

  task automatic t_fault_leaf();
    bit f, e;
    rd_log.delete();
    do_miss({9'h045, 9'h124}, 16'h0003, f, e);
    chk("R4", "fault at second level", e, 1);
    chk("R4", "reads before leaf fault", rd_log.size(), 2);
    repeat (3) @(negedge clk);
    chk("R4", "no refill after leaf fault", fill_valid, 0);
  endtask

  task automatic t_large_leaf();
    bit f, e;
    rd_log.delete();
    do_miss({9'h047, 9'h0A5}, 16'h0011, f, e);
    chk("R5", "large leaf fill", f, 1);
    chk("R5", "large pfn", c_pfn, 44'h300A5);
    chk("R5", "large perm", c_perm, 3'b100);
    chk("R5", "large global", c_glob, 0);
    chk("R5", "single read", rd_log.size(), 1);
  endtask

  task automatic t_ptr_at_last();
    bit f, e;
    do_miss({9'h045, 9'h125}, 16'h0002, f, e);
    chk("R6", "pointer at last level faults", e, 1);
    chk("R6", "no fill", f, 0);
  endtask

  task automatic t_fill_hold();
    logic [43:0] p0;
    fill_ready = 1'b0;
    @(negedge clk);
    miss_vpn = {9'h045, 9'h123}; miss_asid = 16'h0055; miss_valid = 1'b1;
    while (!miss_ready) @(negedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    for (int i = 0; i < 400 && !fill_valid; i++) @(negedge clk);
    chk("R7", "fill waiting", fill_valid, 1);
    p0 = fill_pfn;
    repeat (4) @(negedge clk);
    chk("R7", "fill still held", fill_valid, 1);
    chk("R7", "held pfn stable", fill_pfn, p0);
    chk("R7", "miss blocked while held", miss_ready, 0);
    fill_ready = 1'b1;
    @(negedge clk);
    chk("R7", "fill released", fill_valid, 0);
    chk("R7", "miss ready again", miss_ready, 1);
  endtask

  task automatic t_stall_latency();
    bit f, e;
    lat_cfg = 6; stall_cfg = 3; stall_left = 3;
    rd_log.delete();
    do_miss({9'h045, 9'h123}, 16'h0777, f, e);
    chk("R12", "fill under stalls", f, 1);
    chk("R12", "pfn under stalls", c_pfn, 44'hABCDE);
    chk("R12", "read count under stalls", rd_log.size(), 2);
    lat_cfg = 0; stall_cfg = 0; stall_left = 0;
    do_miss({9'h047, 9'h011}, 16'h0001, f, e);
    chk("R12", "zero-latency large pfn", c_pfn, 44'h30011);
    lat_cfg = 1;
  endtask

  task automatic do_upd(input logic [55:0] a, input bit sa, input bit sd);
    int n0;
    n0 = wa_log.size();
    @(negedge clk);
    upd_addr = a; upd_set_acc = sa; upd_set_dirty = sd; upd_valid = 1'b1;
    while (!upd_ready) @(negedge clk);
    @(negedge clk);
    upd_valid = 1'b0;
    for (int i = 0; i < 400 && wa_log.size() == n0; i++) @(negedge clk);
  endtask

  task automatic t_update();
    logic [63:0] base_pte;
    base_pte = mk_leaf(44'hABCDE, 3'b011, 1);
    rd_log.delete(); wa_log.delete(); wd_log.delete();
    do_upd(L0BASE + 56'h918, 1, 0);
    chk("R9", "write count (acc)", wa_log.size(), 1);
    if (wa_log.size() >= 1) begin
      chk("R9", "read addr", rd_log[0], L0BASE + 56'h918);
      chk("R9", "write addr", wa_log[0], L0BASE + 56'h918);
      chk("R9", "acc write data", wd_log[0], base_pte | 64'h40);
    end
    do_upd(L0BASE + 56'h918, 0, 1);
    if (wa_log.size() >= 2)
      chk("R9", "dirty write data", wd_log[1], base_pte | 64'hC0);
    else chk("R9", "write count (dirty)", wa_log.size(), 2);
  endtask

  task automatic t_priority();
    rd_log.delete(); wa_log.delete(); wd_log.delete();
    @(negedge clk);
    upd_addr = L0BASE + 56'h918; upd_set_acc = 1; upd_set_dirty = 0; upd_valid = 1'b1;
    miss_vpn = {9'h047, 9'h001}; miss_asid = 16'h0009; miss_valid = 1'b1;
    #1;
    chk("R10", "miss_ready low with update", miss_ready, 0);
    chk("R10", "upd_ready", upd_ready, 1);
    @(negedge clk);
    upd_valid = 1'b0;
    while (!miss_ready) @(negedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    for (int i = 0; i < 400 && !fill_valid; i++) @(negedge clk);
    chk("R10", "miss completes after update", fill_valid, 1);
    chk("R10", "read count", rd_log.size(), 2);
    if (rd_log.size() == 2) begin
      chk("R10", "update read first", rd_log[0], L0BASE + 56'h918);
      chk("R10", "miss read second", rd_log[1], ROOT + 56'h238);
    end
    chk("R10", "update write done", wa_log.size(), 1);
    @(negedge clk);
  endtask

  // ---------------- main ----------------
  initial begin
    rst_n = 1'b0;
    root_base = ROOT;
    miss_valid = 0; miss_vpn = '0; miss_asid = '0;
    fill_ready = 1'b1;
    upd_valid = 0; upd_addr = '0; upd_set_acc = 0; upd_set_dirty = 0;
    mem[ROOT + 56'h228]   = mk_ptr(44'h20000);
    mem[ROOT + 56'h238]   = mk_leaf(44'h30000, 3'b100, 0);
    mem[L0BASE + 56'h918] = mk_leaf(44'hABCDE, 3'b011, 1);
    mem[L0BASE + 56'h928] = mk_ptr(44'h40000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk_two_level();
    t_fault_root();
    t_fault_leaf();
    t_large_leaf();
    t_ptr_at_last();
    t_fill_hold();
    t_stall_latency();
    t_update();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule